// File: doc/BRIEF.md
# Two-Wire Register-Pointer Configuration Port

This block is the slave side of an I2C control port. Through it a host reads and writes a small bank of 8-bit configuration registers that the block holds. The block samples the SCL and SDA lines with the system clock. Each line passes through a two-flop synchroniser and a glitch filter. The block drives SDA open-drain: it pulls the line low or releases it, and never drives it high. It answers to a 7-bit device address. The upper five bits of that address are fixed at 1,0,0,1,1 (MSB first). The lower two bits come from two strap pins.

An internal byte-wide pointer selects the register to be accessed. In a write transaction, the byte after the address loads the pointer. Every later byte is written to the register the pointer selects, and the pointer then advances. A read transaction has no pointer byte; it returns registers starting at the pointer. A host that wants to read from a given register first starts a write, sends the pointer byte and then issues a stop. This sets the pointer without changing any register, and the read that follows starts there.

The current register contents are presented as a flat vector for the rest of the chip.

Top module: `i2c_cfg_port`

## Requirements
- R1: The address byte is sent MSB first. Its upper seven bits must equal 1,0,0,1,1,strap_i[1],strap_i[0], and its bit 0 selects the direction (0 = write, 1 = read). On a match the block pulls SDA low for the acknowledge slot.
- R2: On an address mismatch the block gives no acknowledge and keeps SDA released. It changes no register until the next start condition.
- R3: In a write, the first byte after the address loads the pointer. Every later byte is stored in register[pointer], and the pointer then advances. Each of these bytes is acknowledged.
- R4: A stop right after the pointer byte's acknowledge leaves every register unchanged and keeps the new pointer. A following read therefore begins at that pointer.
- R5: A read returns register[pointer] MSB first, and the pointer advances after each byte. An ACK from the host (SDA low in the acknowledge slot) fetches the next register. A NO-ACK makes the block release SDA and stay idle until the next start.
- R6: The bank holds NREG registers (default 17, addresses 0x00 to 0x10). The pointer advances from NREG-1 to 0, for both reads and writes.
- R7: When the pointer is NREG or above, a written byte is discarded and a read returns 0x00. The pointer then advances to 0.
- R8: A stop or a repeated start received in the middle of a byte cancels the transfer. It leaves the registers and the pointer untouched, and SDA is released.
- R9: While rst_n is low, every register takes its RESET_VAL value (all zero by default), the pointer clears and SDA is released.
- R10: The block changes its SDA drive only while the filtered SCL is low.
- R11: A pulse on SCL or SDA shorter than FILT_LEN clock cycles (default 3) has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_i | input | 2 | Low two bits of the device address |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | NREG*8 | Register contents; register i sits in bits i*8+7 : i*8 |

## Verification
The assertions assume the following about the bus:
- Outside start and stop conditions, the host changes SDA only while SCL is low.
- Real bus edges are spaced well beyond the synchroniser and filter delay.
- The host never makes an SDA edge while SCL is high at a moment when the slave is pulling the line low.

The stimulus keeps to this. It uses a quarter-bit time of ten clock cycles, and each SDA change happens a full quarter after SCL falls. The block reacts about six cycles after the fall, so it has released or settled SDA before the host moves.

The glitch case injects a single-cycle SCL pulse. This is shorter than the filter window, so it stays inside the assumptions.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_MAP,
        ST_WDATA,
        ST_SACK,
        ST_RDATA,
        ST_MACK
    } port_st_e;

    typedef struct packed {
        port_st_e   st;
        port_st_e   after;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic [7:0] ptr;
        logic       sda_oe;
        logic       more;
        logic       scl_p;
        logic       sda_p;
    } port_s;

    function automatic logic [7:0] ptr_step(input logic [7:0] p, input int nreg);
        if (int'(p) >= nreg - 1) return 8'd0;
        return p + 8'd1;
    endfunction

endpackage

// File: rtl/i2c_cfg_filter.sv
module i2c_cfg_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_i,
    output logic out_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          out;
        logic [CW-1:0] cnt;
    } filt_s;

    filt_s flt_d, flt_q;

    always_comb begin
        flt_d    = flt_q;
        flt_d.s1 = in_i;
        flt_d.s2 = flt_q.s1;
        if (flt_q.s2 != flt_q.out) begin
            if (flt_q.cnt == CW'(FILT_LEN - 1)) begin
                flt_d.out = flt_q.s2;
                flt_d.cnt = '0;
            end else begin
                flt_d.cnt = flt_q.cnt + 1'b1;
            end
        end else begin
            flt_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= '{s1: 1'b1, s2: 1'b1, out: 1'b1, cnt: '0};
        end else begin
            flt_q <= flt_d;
        end
    end

    assign out_o = flt_q.out;

    // R11: the output moves only after the synchronised input has differed for a full window
    assert_filter_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flt_q.out) |-> ($past(flt_q.cnt) == CW'(FILT_LEN - 1)));

endmodule

// File: rtl/i2c_cfg_bank.sv
module i2c_cfg_bank #(
    parameter int              NREG      = 17,
    parameter logic [NREG*8-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [7:0]        wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic [7:0]        rd_addr_i,
    output logic [7:0]        rd_data_o,
    output logic [NREG*8-1:0] regs_o
);
    localparam int AW = $clog2(NREG);

    logic [NREG-1:0][7:0] bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en_i && int'(wr_addr_i) < NREG) begin
            bank_d[wr_addr_i[AW-1:0]] = wr_data_i;
        end
    end

    always_comb begin
        rd_data_o = 8'd0;
        for (int i = 0; i < NREG; i++) begin
            if (int'(rd_addr_i) == i) rd_data_o = bank_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= RESET_VAL;
        else        bank_q <= bank_d;
    end

    assign regs_o = bank_q;

    // R4: contents hold when no write strobe is given
    assert_bank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(bank_q));

    // R7: a strobe aimed past the bank end changes nothing
    assert_oob_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && int'(wr_addr_i) >= NREG) |=> $stable(bank_q));

endmodule

// File: rtl/i2c_cfg_port.sv
module i2c_cfg_port
    import i2c_cfg_pkg::*;
#(
    parameter int                NREG      = 17,
    parameter int                FILT_LEN  = 3,
    parameter logic [4:0]        DEV_HI    = 5'b10011,
    parameter logic [NREG*8-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        strap_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [NREG*8-1:0] regs_o
);
    localparam logic [3:0] BYTE_BITS = 4'd8;

    logic [1:0] line_raw, line_flt;
    logic       scl_f, sda_f;

    assign line_raw = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        i2c_cfg_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .in_i  (line_raw[g]),
            .out_o (line_flt[g])
        );
    end

    assign scl_f = line_flt[0];
    assign sda_f = line_flt[1];

    port_s      st_d, st_q;
    logic       start_ev, stop_ev, scl_rise, scl_fall;
    logic       wr_en;
    logic [7:0] wr_addr, wr_data, rd_byte;

    assign start_ev = scl_f & st_q.scl_p & st_q.sda_p & ~sda_f;
    assign stop_ev  = scl_f & st_q.scl_p & ~st_q.sda_p & sda_f;
    assign scl_rise = scl_f & ~st_q.scl_p;
    assign scl_fall = ~scl_f & st_q.scl_p;

    i2c_cfg_bank #(.NREG(NREG), .RESET_VAL(RESET_VAL)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (st_q.ptr),
        .rd_data_o (rd_byte),
        .regs_o    (regs_o)
    );

    always_comb begin
        st_d       = st_q;
        wr_en      = 1'b0;
        wr_addr    = st_q.ptr;
        wr_data    = st_q.sh;
        st_d.scl_p = scl_f;
        st_d.sda_p = sda_f;
        if (start_ev) begin
            st_d.st     = ST_ADDR;
            st_d.cnt    = '0;
            st_d.sda_oe = 1'b0;
        end else if (stop_ev) begin
            st_d.st     = ST_IDLE;
            st_d.cnt    = '0;
            st_d.sda_oe = 1'b0;
        end else begin
            unique case (st_q.st)
                ST_ADDR, ST_MAP, ST_WDATA: begin
                    if (scl_rise && st_q.cnt != BYTE_BITS) begin
                        st_d.sh  = {st_q.sh[6:0], sda_f};
                        st_d.cnt = st_q.cnt + 4'd1;
                    end else if (scl_fall && st_q.cnt == BYTE_BITS) begin
                        st_d.cnt = '0;
                        if (st_q.st == ST_ADDR) begin
                            if (st_q.sh[7:1] == {DEV_HI, strap_i}) begin
                                st_d.sda_oe = 1'b1;
                                st_d.st     = ST_SACK;
                                st_d.after  = st_q.sh[0] ? ST_RDATA : ST_MAP;
                            end else begin
                                st_d.st = ST_IDLE;
                            end
                        end else if (st_q.st == ST_MAP) begin
                            st_d.ptr    = st_q.sh;
                            st_d.sda_oe = 1'b1;
                            st_d.st     = ST_SACK;
                            st_d.after  = ST_WDATA;
                        end else begin
                            wr_en       = 1'b1;
                            st_d.ptr    = ptr_step(st_q.ptr, NREG);
                            st_d.sda_oe = 1'b1;
                            st_d.st     = ST_SACK;
                            st_d.after  = ST_WDATA;
                        end
                    end
                end
                ST_SACK: begin
                    if (scl_fall) begin
                        st_d.sda_oe = 1'b0;
                        st_d.cnt    = '0;
                        st_d.st     = st_q.after;
                        if (st_q.after == ST_RDATA) begin
                            st_d.sh     = rd_byte;
                            st_d.sda_oe = ~rd_byte[7];
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise && st_q.cnt != BYTE_BITS) begin
                        st_d.cnt = st_q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (st_q.cnt == BYTE_BITS) begin
                            st_d.sda_oe = 1'b0;
                            st_d.ptr    = ptr_step(st_q.ptr, NREG);
                            st_d.cnt    = '0;
                            st_d.more   = 1'b0;
                            st_d.st     = ST_MACK;
                        end else begin
                            st_d.sh     = {st_q.sh[6:0], 1'b0};
                            st_d.sda_oe = ~st_q.sh[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        st_d.more = ~sda_f;
                    end else if (scl_fall) begin
                        if (st_q.more) begin
                            st_d.sh     = rd_byte;
                            st_d.sda_oe = ~rd_byte[7];
                            st_d.st     = ST_RDATA;
                        end else begin
                            st_d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: ST_IDLE, after: ST_IDLE, cnt: '0, sh: '0, ptr: '0,
                      sda_oe: 1'b0, more: 1'b0, scl_p: 1'b1, sda_p: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe_o = st_q.sda_oe;

    // R10: SDA drive moves only while the filtered clock is low
    assert_sda_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.sda_oe) |-> !$past(scl_f));

    // R8: a start condition always restarts address reception
    assert_start_to_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (st_q.st == ST_ADDR));

    // R8: a stop always leaves the bus released and the port idle
    assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (!st_q.sda_oe && st_q.st == ST_IDLE));

    // R2: an idle port never pulls the data line
    assert_idle_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == ST_IDLE) |-> !st_q.sda_oe);

    // R6: a write at the last register sends the pointer back to zero
    assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(st_q.ptr) == NREG - 1) |=> (st_q.ptr == 8'd0));

endmodule

// File: tb/sim_i2c_cfg_port.sv
`timescale 1ns/1ps
module sim_i2c_cfg_port;
    localparam int NREG = 17;
    localparam int Q    = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        strap = 2'b01;
    logic              scl_m = 1'b1;
    logic              sda_m = 1'b1;
    logic              sda_oe;
    logic [NREG*8-1:0] regs;
    logic              sda_w;
    logic              glitch_on = 1'b0;
    logic              done = 1'b0;
    logic              prev_oe = 1'b0;
    int                checks = 0;
    int                fails = 0;
    int                r10_viol = 0;
    logic [7:0]        exp_r [NREG];

    always #2 clk = ~clk;

    assign sda_w = sda_m & ~sda_oe;

    i2c_cfg_port u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_i  (strap),
        .scl_i    (scl_m),
        .sda_i    (sda_w),
        .sda_oe_o (sda_oe),
        .regs_o   (regs)
    );

    always @(negedge clk) begin
        if (rst_n && sda_oe !== prev_oe && scl_m) r10_viol++;
        prev_oe <= sda_oe;
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = exp_r[i];
        checks++;
        if (regs !== v) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, regs, v);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(Q);
        scl_m = 1'b1; wt(2*Q);
        sda_m = 1'b0; wt(2*Q);
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(Q);
        scl_m = 1'b1; wt(2*Q);
        sda_m = 1'b1; wt(2*Q);
    endtask

    task automatic wbit(input logic b);
        sda_m = b;
        if (glitch_on) begin
            wt(3); scl_m = 1'b1; wt(1); scl_m = 1'b0; wt(Q-4);
        end else begin
            wt(Q);
        end
        scl_m = 1'b1; wt(2*Q);
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic rbit(output logic b);
        sda_m = 1'b1; wt(Q);
        scl_m = 1'b1; wt(Q);
        b = sda_w;    wt(Q);
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) wbit(b[i]);
        rbit(x);
        ack = ~x;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            rbit(x);
            b[i] = x;
        end
        wbit(~mack);
    endtask

    function automatic logic [7:0] dev(input logic [1:0] s, input logic rw);
        return {5'b10011, s, rw};
    endfunction

    task automatic set_ptr(input logic [7:0] p);
        logic a;
        bus_start();
        send_byte(dev(strap, 1'b0), a);
        send_byte(p, a);
        bus_stop();
    endtask

    task automatic t_reset();
        for (int i = 0; i < NREG; i++) exp_r[i] = 8'h00;
        check_regs("R9 registers at reset");
        check("R9 sda released at reset", 32'(sda_oe), 32'd0);
    endtask

    task automatic t_write_burst();
        logic a0, a1, a2, a3;
        bus_start();
        send_byte(dev(strap, 1'b0), a0);
        send_byte(8'h03, a1);
        send_byte(8'hA5, a2);
        send_byte(8'h3C, a3);
        bus_stop();
        exp_r[3] = 8'hA5; exp_r[4] = 8'h3C;
        check("R1 address ack", 32'(a0), 32'd1);
        check("R3 pointer and data acks", 32'({a1, a2, a3}), 32'b111);
        check_regs("R3 burst write");
    endtask

    task automatic t_addr_mismatch();
        logic a0, a1, a2;
        strap = 2'b10;
        bus_start();
        send_byte(dev(2'b01, 1'b0), a0);
        send_byte(8'h03, a1);
        send_byte(8'hFF, a2);
        bus_stop();
        check("R2 no ack on wrong strap bits", 32'({a0, a1, a2}), 32'd0);
        check_regs("R2 registers untouched");
        bus_start();
        send_byte(dev(2'b10, 1'b0), a0);
        send_byte(8'h02, a1);
        send_byte(8'h21, a2);
        bus_stop();
        exp_r[2] = 8'h21;
        check("R1 ack with new strap value", 32'(a0), 32'd1);
        check_regs("R1 write after strap change");
        strap = 2'b01;
    endtask

    task automatic t_abort_then_read();
        logic       a;
        logic [7:0] d;
        set_ptr(8'h04);
        check_regs("R4 aborted write leaves registers");
        bus_start();
        send_byte(dev(strap, 1'b1), a);
        recv_byte(1'b0, d);
        bus_stop();
        check("R4 read starts at kept pointer", 32'(d), 32'(exp_r[4]));
    endtask

    task automatic t_read_burst();
        logic       a;
        logic [7:0] d0, d1, d2;
        set_ptr(8'h02);
        bus_start();
        send_byte(dev(strap, 1'b1), a);
        recv_byte(1'b1, d0);
        recv_byte(1'b1, d1);
        recv_byte(1'b0, d2);
        check("R5 sda released after no-ack", 32'(sda_oe), 32'd0);
        bus_stop();
        check("R5 read ack", 32'(a), 32'd1);
        check("R5 first read byte", 32'(d0), 32'(exp_r[2]));
        check("R5 second read byte", 32'(d1), 32'(exp_r[3]));
        check("R5 third read byte", 32'(d2), 32'(exp_r[4]));
    endtask

    task automatic t_wrap();
        logic       a;
        logic [7:0] d0, d1;
        bus_start();
        send_byte(dev(strap, 1'b0), a);
        send_byte(8'h10, a);
        send_byte(8'h77, a);
        send_byte(8'h88, a);
        bus_stop();
        exp_r[16] = 8'h77; exp_r[0] = 8'h88;
        check_regs("R6 write wraps to register 0");
        set_ptr(8'h10);
        bus_start();
        send_byte(dev(strap, 1'b1), a);
        recv_byte(1'b1, d0);
        recv_byte(1'b0, d1);
        bus_stop();
        check("R6 read at last register", 32'(d0), 32'h77);
        check("R6 read wraps to register 0", 32'(d1), 32'h88);
    endtask

    task automatic t_out_of_range();
        logic       a;
        logic [7:0] d0, d1;
        bus_start();
        send_byte(dev(strap, 1'b0), a);
        send_byte(8'h20, a);
        send_byte(8'h55, a);
        send_byte(8'h66, a);
        bus_stop();
        exp_r[0] = 8'h66;
        check_regs("R7 out-of-range write dropped, next goes to 0");
        set_ptr(8'h1F);
        bus_start();
        send_byte(dev(strap, 1'b1), a);
        recv_byte(1'b1, d0);
        recv_byte(1'b0, d1);
        bus_stop();
        check("R7 out-of-range read gives zero", 32'(d0), 32'h00);
        check("R7 pointer wraps to 0 after range", 32'(d1), 32'h66);
    endtask

    task automatic t_cancel();
        logic       a;
        logic [7:0] d;
        bus_start();
        send_byte(dev(strap, 1'b0), a);
        send_byte(8'h05, a);
        send_byte(8'h5A, a);
        send_byte(8'h6B, a);
        bus_stop();
        exp_r[5] = 8'h5A; exp_r[6] = 8'h6B;
        bus_start();
        send_byte(dev(strap, 1'b0), a);
        send_byte(8'h06, a);
        for (int i = 0; i < 4; i++) wbit(1'b0);
        bus_stop();
        check_regs("R8 stop mid-byte writes nothing");
        check("R8 sda released after stop", 32'(sda_oe), 32'd0);
        bus_start();
        send_byte(dev(strap, 1'b1), a);
        recv_byte(1'b0, d);
        bus_stop();
        check("R8 pointer kept after stop mid-byte", 32'(d), 32'h6B);
        bus_start();
        send_byte(dev(strap, 1'b0), a);
        send_byte(8'h05, a);
        for (int i = 0; i < 3; i++) wbit(1'b1);
        bus_start();
        send_byte(dev(strap, 1'b1), a);
        recv_byte(1'b0, d);
        bus_stop();
        check("R8 repeated start mid-byte keeps pointer", 32'(d), 32'h5A);
        check_regs("R8 repeated start mid-byte writes nothing");
    endtask

    task automatic t_glitch();
        logic a0, a1, a2;
        bus_start();
        send_byte(dev(strap, 1'b0), a0);
        send_byte(8'h07, a1);
        glitch_on = 1'b1;
        send_byte(8'hC9, a2);
        glitch_on = 1'b0;
        bus_stop();
        exp_r[7] = 8'hC9;
        check("R11 acks with short SCL pulses", 32'({a0, a1, a2}), 32'b111);
        check_regs("R11 short SCL pulses ignored");
    endtask

    initial begin
        wt(5);
        rst_n = 1'b1;
        wt(5);
        t_reset();
        t_write_burst();
        t_addr_mismatch();
        t_abort_then_read();
        t_read_burst();
        t_wrap();
        t_out_of_range();
        t_cancel();
        t_glitch();
        check("R10 sda drive changed only with SCL low", 32'(r10_viol), 32'd0);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule